// File: doc/BRIEF.md
# Data-Port I/O Decoder with Guarded Code-Memory Write Window

This block sits on the data-memory port of a small processor, in front of its RAM. Each request carries an address. The block keeps only the low 17 bits of that address. When bit 16 of the kept address is clear, the block passes the access on to RAM as a 16-bit word address. When bit 16 is set, the access goes to a small set of I/O registers:

- a console byte port, for both output and input;
- a timer that counts clock cycles divided by a prescale factor;
- a debug output register;
- an exit register that requests a halt.

The I/O space also holds a guarded window of three registers for writing code memory: a key register, an address register and a data register. A write to the data register becomes a code-memory write only after the exact 32-bit key has been written. Each accepted data word moves the held address forward by 4. A read of an I/O offset that is not defined raises a fault pulse. A write to an undefined I/O offset is dropped.

Every output is registered. A request sampled on clock edge k shows its result after edge k, and strobes last one cycle. The processor reads register 0 continuously and drives it onto `exitValue`. The exit register reports that value as the halt code.

Top module: `dmem_io_decoder`

## Requirements
- R1: The request address is reduced to its low 17 bits. With bit 16 clear, the block raises `ramReq` for one cycle after the request edge. Alongside it appear `ramWrite`, `ramAddr` (address bits 15:0) and `ramWdata`, and no I/O strobe fires.
- R2: A write to offset 0x10000 pulses `conOutValid`, with `conOutByte` set to data bits 7:0.
- R3: A write to offset 0x1FFF8 pulses `dbgValid`, with `dbgData` set to the written word.
- R4: A write to offset 0x1FFFC pulses `haltValid`, with `haltCode` set to `exitValue` as sampled at the request edge.
- R5: A write to offset 0x1FC80 unlocks the window when the data equals 0x1337F7D1. Any other value locks it.
- R6: A write to offset 0x1FC84 loads the window address. While the window is unlocked, a write to offset 0x1FC88 pulses `imWrEn` with `imWrAddr` set to the held address and `imWrData` set to the data. The held address then increases by 4.
- R7: While the window is locked, a write to 0x1FC88 produces no output, and the held address keeps its value.
- R8: A read of offset 0x1FFF4 returns, through `rdValid` and `rdData`, a tick count. The tick count increases by exactly one every PRESCALE clock cycles, starting from zero at reset.
- R9: A read of offset 0x10000 returns `conInByte`, zero-extended, through `rdValid` and `rdData`.
- R10: A read of any other I/O offset pulses `illegalRead`. A write to any undefined I/O offset produces no output.
- R11: After reset the window is locked, the held address is 0, the tick count is 0 and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Data-port request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | BUS_W | Data byte address (only the low 17 bits are used) |
| reqWdata | input | DATA_W | Write data |
| exitValue | input | DATA_W | Current value of register 0 |
| conInByte | input | 8 | Console input byte |
| ramReq | output | 1 | RAM access strobe |
| ramWrite | output | 1 | RAM access direction |
| ramAddr | output | ADDR_W-1 | RAM address |
| ramWdata | output | DATA_W | RAM write data |
| rdValid | output | 1 | I/O read data valid |
| rdData | output | DATA_W | I/O read data |
| imWrEn | output | 1 | Code-memory write strobe |
| imWrAddr | output | DATA_W | Code-memory write address |
| imWrData | output | DATA_W | Code-memory write data |
| conOutValid | output | 1 | Console output strobe |
| conOutByte | output | 8 | Console output byte |
| dbgValid | output | 1 | Debug output strobe |
| dbgData | output | DATA_W | Debug output word |
| haltValid | output | 1 | Halt request strobe |
| haltCode | output | DATA_W | Exit code |
| illegalRead | output | 1 | Undefined I/O read fault |

## Verification
The bench builds the block with PRESCALE = 5 and keeps the default 17-bit decode and 32-bit data. With the short prescale, a gap of fifteen cycles between two timer reads has to show a difference of exactly three ticks, so the tick arithmetic is checked within a few dozen cycles. The full-width address and data defaults let the bench test the real key value, the masking of high address bits, and address stepping across several window writes.

// File: rtl/dmem_io_pkg.sv
package dmem_io_pkg;
  typedef struct packed {
    logic ramAcc;
    logic conOut;
    logic dbgOut;
    logic haltReq;
    logic ldUnlock;
    logic ldAddr;
    logic imPush;
    logic rdTimer;
    logic rdConsole;
    logic rdIllegal;
  } ioStrobes_t;
endpackage

// File: rtl/dmem_io_ctrl.sv
module dmem_io_ctrl
  import dmem_io_pkg::*;
#(
  parameter int unsigned BUS_W       = 32,
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned OFF_CONSOLE = 32'h1_0000,
  parameter int unsigned OFF_KEY     = 32'h1_FC80,
  parameter int unsigned OFF_IMADDR  = 32'h1_FC84,
  parameter int unsigned OFF_IMDATA  = 32'h1_FC88,
  parameter int unsigned OFF_TIMER   = 32'h1_FFF4,
  parameter int unsigned OFF_DEBUG   = 32'h1_FFF8,
  parameter int unsigned OFF_EXIT    = 32'h1_FFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [BUS_W-1:0] reqAddr,
  output ioStrobes_t       strobes
);
  localparam int unsigned IO_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] offs;
  logic              isIo;
  logic [31:0]       offs32;

  assign offs   = reqAddr[ADDR_W-1:0];
  assign isIo   = offs[IO_BIT];
  assign offs32 = 32'(offs);

  always_comb begin
    strobes = '0;
    if (reqValid) begin
      if (!isIo) begin
        strobes.ramAcc = 1'b1;
      end else if (reqWrite) begin
        strobes.conOut   = (offs32 == OFF_CONSOLE);
        strobes.dbgOut   = (offs32 == OFF_DEBUG);
        strobes.haltReq  = (offs32 == OFF_EXIT);
        strobes.ldUnlock = (offs32 == OFF_KEY);
        strobes.ldAddr   = (offs32 == OFF_IMADDR);
        strobes.imPush   = (offs32 == OFF_IMDATA);
      end else begin
        strobes.rdTimer   = (offs32 == OFF_TIMER);
        strobes.rdConsole = (offs32 == OFF_CONSOLE);
        strobes.rdIllegal = !((offs32 == OFF_TIMER) || (offs32 == OFF_CONSOLE));
      end
    end
  end

  // R1: a low-half address never reaches I/O decode
  p_low_half_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqAddr[IO_BIT]) |-> (strobes.ramAcc && $countones(strobes) == 1));

  // R10: a fault is only ever raised by a read
  p_fault_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdIllegal |-> (reqValid && !reqWrite));

  // R1: at most one target per request
  p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
endmodule

// File: rtl/dmem_io_dp.sv
module dmem_io_dp
  import dmem_io_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RAM_AW     = 16,
  parameter int unsigned PRESCALE   = 100,
  parameter int unsigned IM_STEP    = 4,
  parameter logic [31:0] UNLOCK_KEY = 32'h1337_F7D1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ioStrobes_t        strobes,
  input  logic              reqWrite,
  input  logic [RAM_AW-1:0] reqAddrLow,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] exitValue,
  input  logic [7:0]        conInByte,
  output logic              ramReq,
  output logic              ramWrite,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              imWrEn,
  output logic [DATA_W-1:0] imWrAddr,
  output logic [DATA_W-1:0] imWrData,
  output logic              conOutValid,
  output logic [7:0]        conOutByte,
  output logic              dbgValid,
  output logic [DATA_W-1:0] dbgData,
  output logic              haltValid,
  output logic [DATA_W-1:0] haltCode,
  output logic              illegalRead
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] tickCnt;
  logic              unlocked;
  logic [DATA_W-1:0] imAddrReg;
  logic              pushOk;

  assign pushOk = strobes.imPush && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      imAddrReg <= '0;
    end else begin
      if (strobes.ldUnlock) unlocked <= (reqWdata == DATA_W'(UNLOCK_KEY));
      if (pushOk)               imAddrReg <= imAddrReg + DATA_W'(IM_STEP);
      else if (strobes.ldAddr)  imAddrReg <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramReq <= 1'b0; ramWrite <= 1'b0; ramAddr <= '0; ramWdata <= '0;
      rdValid <= 1'b0; rdData <= '0;
      imWrEn <= 1'b0; imWrAddr <= '0; imWrData <= '0;
      conOutValid <= 1'b0; conOutByte <= '0;
      dbgValid <= 1'b0; dbgData <= '0;
      haltValid <= 1'b0; haltCode <= '0;
      illegalRead <= 1'b0;
    end else begin
      ramReq      <= strobes.ramAcc;
      conOutValid <= strobes.conOut;
      dbgValid    <= strobes.dbgOut;
      haltValid   <= strobes.haltReq;
      illegalRead <= strobes.rdIllegal;
      imWrEn      <= pushOk;
      rdValid     <= strobes.rdTimer || strobes.rdConsole;
      if (strobes.ramAcc) begin
        ramWrite <= reqWrite;
        ramAddr  <= reqAddrLow;
        ramWdata <= reqWdata;
      end
      if (strobes.conOut)  conOutByte <= reqWdata[7:0];
      if (strobes.dbgOut)  dbgData    <= reqWdata;
      if (strobes.haltReq) haltCode   <= exitValue;
      if (pushOk) begin
        imWrAddr <= imAddrReg;
        imWrData <= reqWdata;
      end
      if (strobes.rdTimer)        rdData <= tickCnt;
      else if (strobes.rdConsole) rdData <= DATA_W'(conInByte);
    end
  end

  // R6: an accepted window word advances the held address by the step
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.imPush && unlocked) |=> (imAddrReg == $past(imAddrReg) + DATA_W'(IM_STEP)));

  // R7: a code-memory write is only seen after an unlocked cycle
  p_locked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    imWrEn |-> $past(unlocked));

  // R8: the tick count only ever moves by one
  p_tick_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tickCnt != $past(tickCnt)) |-> (tickCnt == $past(tickCnt) + 1'b1));

  // R8: prescaler stays in range
  p_pre_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= PRE_LAST);
endmodule

// File: rtl/dmem_io_decoder.sv
module dmem_io_decoder
  import dmem_io_pkg::*;
#(
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PRESCALE   = 100,
  parameter logic [31:0] UNLOCK_KEY = 32'h1337_F7D1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] exitValue,
  input  logic [7:0]        conInByte,
  output logic              ramReq,
  output logic              ramWrite,
  output logic [ADDR_W-2:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              imWrEn,
  output logic [DATA_W-1:0] imWrAddr,
  output logic [DATA_W-1:0] imWrData,
  output logic              conOutValid,
  output logic [7:0]        conOutByte,
  output logic              dbgValid,
  output logic [DATA_W-1:0] dbgData,
  output logic              haltValid,
  output logic [DATA_W-1:0] haltCode,
  output logic              illegalRead
);
  localparam int unsigned RAM_AW = ADDR_W - 1;

  ioStrobes_t strobes;

  dmem_io_ctrl #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .strobes(strobes)
  );

  dmem_io_dp #(.DATA_W(DATA_W), .RAM_AW(RAM_AW), .PRESCALE(PRESCALE),
               .UNLOCK_KEY(UNLOCK_KEY)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqWrite(reqWrite),
    .reqAddrLow(reqAddr[RAM_AW-1:0]), .reqWdata(reqWdata),
    .exitValue(exitValue), .conInByte(conInByte),
    .ramReq(ramReq), .ramWrite(ramWrite), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .rdValid(rdValid), .rdData(rdData),
    .imWrEn(imWrEn), .imWrAddr(imWrAddr), .imWrData(imWrData),
    .conOutValid(conOutValid), .conOutByte(conOutByte),
    .dbgValid(dbgValid), .dbgData(dbgData),
    .haltValid(haltValid), .haltCode(haltCode),
    .illegalRead(illegalRead)
  );
endmodule

// File: tb/dmem_io_decoder_tb_top.sv
module dmem_io_decoder_tb_top;
  localparam int unsigned PRE = 5;
  localparam logic [31:0] KEY = 32'h1337_F7D1;
  localparam logic [31:0] EXITV = 32'h0000_002A;
  localparam logic [7:0]  CONIN = 8'h5C;

  localparam int K_RAMW = 0, K_RAMR = 1, K_CON = 2, K_DBG = 3, K_HALT = 4,
                 K_IM = 5, K_NONE = 6, K_ILL = 7, K_CRD = 8;
  localparam int NV = 16;

  localparam logic V_WR [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,0,1,0,0};
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0000_1234, 32'hFFFE_1234, 32'h0001_0000, 32'h0001_FFF8,
    32'h0001_FC88, 32'h0001_FC80, 32'h0001_FC84, 32'h0001_FC88,
    32'h0001_FC88, 32'h0001_FC80, 32'h0001_FC88, 32'h0001_F000,
    32'h0001_F000, 32'h0001_FFFC, 32'h0001_0000, 32'h0000_0400};
  localparam logic [31:0] V_DATA [NV] = '{
    32'h5, 32'h77, 32'h1A5, 32'hDEAD_BEEF,
    32'h1, KEY, 32'h100, 32'hAAAA,
    32'hBBBB, KEY + 32'h1, 32'hCCCC, 32'h9,
    32'h0, 32'h0, 32'h0, 32'h0};
  localparam int V_KIND [NV] = '{
    K_RAMW, K_RAMW, K_CON, K_DBG, K_NONE, K_NONE, K_NONE, K_IM,
    K_IM, K_NONE, K_NONE, K_NONE, K_ILL, K_HALT, K_CRD, K_RAMR};
  localparam logic [31:0] V_EXP [NV] = '{
    32'h1234, 32'h1234, 32'hA5, 32'hDEAD_BEEF, 0, 0, 0, 32'h100,
    32'h104, 0, 0, 0, 0, EXITV, 32'h5C, 32'h400};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [31:0] exitValue = EXITV;
  logic [7:0]  conInByte = CONIN;
  logic ramReq, ramWrite, rdValid, imWrEn, conOutValid, dbgValid, haltValid, illegalRead;
  logic [15:0] ramAddr;
  logic [31:0] ramWdata, rdData, imWrAddr, imWrData, dbgData, haltCode;
  logic [7:0]  conOutByte;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dmem_io_decoder #(.PRESCALE(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .exitValue(exitValue),
    .conInByte(conInByte), .ramReq(ramReq), .ramWrite(ramWrite),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .rdValid(rdValid), .rdData(rdData),
    .imWrEn(imWrEn), .imWrAddr(imWrAddr), .imWrData(imWrData),
    .conOutValid(conOutValid), .conOutByte(conOutByte), .dbgValid(dbgValid),
    .dbgData(dbgData), .haltValid(haltValid), .haltCode(haltCode),
    .illegalRead(illegalRead)
  );

  function automatic logic [6:0] strobeVec();
    return {ramReq, rdValid, imWrEn, conOutValid, dbgValid, haltValid, illegalRead};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] t1;
    repeat (3) @(posedge clk);
    #1;
    check(strobeVec() == 0, "R11 strobes low in reset", 32'(strobeVec()), 0);
    doReset();
    // R11 / R8: tick starts at zero
    access(1'b0, 32'h0001_FFF4, 0);
    check(rdValid && rdData == 0, "R11 R8 tick zero after reset", rdData, 0);

    for (int i = 0; i < NV; i++) begin
      access(V_WR[i], V_ADDR[i], V_DATA[i]);
      case (V_KIND[i])
        K_RAMW: check(strobeVec() == 7'b1000000 && ramWrite && ramAddr == V_EXP[i][15:0]
                      && ramWdata == V_DATA[i], "R1 ram write", 32'(ramAddr), V_EXP[i]);
        K_RAMR: check(strobeVec() == 7'b1000000 && !ramWrite && ramAddr == V_EXP[i][15:0],
                      "R1 ram read", 32'(ramAddr), V_EXP[i]);
        K_CON:  check(strobeVec() == 7'b0001000 && conOutByte == V_EXP[i][7:0],
                      "R2 console byte", 32'(conOutByte), V_EXP[i]);
        K_DBG:  check(strobeVec() == 7'b0000100 && dbgData == V_EXP[i],
                      "R3 debug word", dbgData, V_EXP[i]);
        K_HALT: check(strobeVec() == 7'b0000010 && haltCode == V_EXP[i],
                      "R4 halt code", haltCode, V_EXP[i]);
        K_IM:   check(strobeVec() == 7'b0010000 && imWrAddr == V_EXP[i]
                      && imWrData == V_DATA[i], "R6 window write", imWrAddr, V_EXP[i]);
        K_NONE: check(strobeVec() == 0, "R5 R7 R10 no output", 32'(strobeVec()), 0);
        K_ILL:  check(strobeVec() == 7'b0000001, "R10 illegal read", 32'(strobeVec()), 1);
        K_CRD:  check(strobeVec() == 7'b0100000 && rdData == V_EXP[i],
                      "R9 console read", rdData, V_EXP[i]);
        default: check(1'b0, "table kind", 0, 0);
      endcase
    end

    // R7: locked push left held address (0x108) intact
    access(1'b1, 32'h0001_FC80, KEY);
    access(1'b1, 32'h0001_FC88, 32'h1111);
    check(imWrEn && imWrAddr == 32'h108, "R7 address kept while locked", imWrAddr, 32'h108);
    // R5: relock with a different value
    access(1'b1, 32'h0001_FC80, 32'h0);
    access(1'b1, 32'h0001_FC88, 32'h2222);
    check(!imWrEn, "R5 zero value relocks", 32'(imWrEn), 0);

    // R8: 15-cycle gap = 3 ticks
    access(1'b0, 32'h0001_FFF4, 0);
    t1 = rdData;
    repeat (14) @(posedge clk);
    access(1'b0, 32'h0001_FFF4, 0);
    check(rdValid && rdData == t1 + 3, "R8 tick rate", rdData, t1 + 3);

    // R11: reset relocks and clears held address
    access(1'b1, 32'h0001_FC80, KEY);
    doReset();
    access(1'b1, 32'h0001_FC88, 32'h3333);
    check(!imWrEn, "R11 locked after reset", 32'(imWrEn), 0);
    access(1'b1, 32'h0001_FC80, KEY);
    access(1'b1, 32'h0001_FC88, 32'h4444);
    check(imWrEn && imWrAddr == 0, "R11 address zero after reset", imWrAddr, 0);

    // R1: bit 16 set in a high-masked address still decodes as I/O
    access(1'b1, 32'hABC1_0000, 32'h42);
    check(conOutValid && conOutByte == 8'h42, "R1 R2 masked I/O address",
          32'(conOutByte), 32'h42);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule